// File: doc/BRIEF.md
# SDRAM Command State Checker

This block watches the control pins of a single SDRAM device on every clock and tells whether each command is allowed in the state the device is in. It decodes the chip-select, row-strobe, column-strobe and write-enable levels into a command. It keeps one global state for the whole device: idle, row open, write recovery with or without automatic precharge, precharging, refresh cycle, mode-register load, power-down and self refresh. The timed states end on their own after a parameter number of clocks.

An illegal command raises a one-cycle flag. The flag comes with the code of the offending command and its bank address. The tracked state and the remaining wait count stay where they were, so a single bad command does not throw the tracker off the real device. The clock-enable pin gates the command table: a command is only judged if clock enable was high at the previous edge. A falling clock enable while idle starts power-down or self refresh. The block is passive and is meant to sit on the command bus of a memory controller during simulation or in silicon debug logic.

Top module: `sdcmd_tracker`

## Requirements
- R1: With cs_n high the command is deselect (code 0). With cs_n low, ras_n/cas_n/we_n decode as 111 no-op (1), 110 burst stop (2), 101 read (3), 100 write (4), 011 activate (5), 010 precharge (6), 001 refresh (7), 000 mode-register load (8). These codes appear on illegal_cmd_o.
- R2: In idle (state_o 0), read and write are illegal. Activate moves to row open (1), refresh moves to refreshing (5) and mode-register load moves to mode-register load (6). Deselect, no-op, burst stop and precharge leave the state at idle.
- R3: In row open (1), activate, refresh and mode-register load are illegal. A write moves to write recovery (2), or to write recovery with auto-precharge (3) when a10 is high. A read with a10 high or any precharge moves to precharging (4). A read with a10 low keeps the row open.
- R4: Write recovery (2) lasts T_WR cycles and then returns to row open. Deselect, no-op and burst stop are accepted. A new write restarts the wait and a10 picks state 2 or 3. A read ends the recovery: a10 low goes to state 1, a10 high goes to state 4. Activate, precharge, refresh and mode-register load are illegal.
- R5: Write recovery with auto-precharge (3) accepts only deselect, no-op and burst stop. It moves to precharging after T_WR cycles.
- R6: Precharging (4) accepts only deselect, no-op and burst stop. It returns to idle after T_RP cycles.
- R7: Refreshing (5) accepts only deselect, no-op and burst stop. It returns to idle after T_RC cycles.
- R8: Mode-register load (6) accepts only deselect and no-op. It returns to idle after T_MRD cycles.
- R9: An illegal command sets illegal_o high in the cycle after the edge that sampled it. illegal_cmd_o shows the command code and illegal_ba_o shows the bank. The state and the remaining wait do not change. When illegal_o is low, illegal_cmd_o and illegal_ba_o read 0.
- R10: When clock enable was low at the previous edge, the command on the pins is ignored outside power-down and self refresh. It raises no flag, and timed states keep counting.
- R11: In idle, clock enable falling (high at the previous edge, low now) with no-op or deselect enters power-down (7). With refresh it enters self refresh (8). Any other command is illegal. Both power states return to idle at the first edge where clock enable is high, and they ignore the command pins.
- R12: A synchronous reset puts the tracker in idle with the wait cleared and no flag. Clock enable counts as high, so the first command after reset is judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable pin of the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge bit for read/write |
| state_o | output | 4 | Tracked state code |
| illegal_o | output | 1 | One-cycle flag for an illegal command |
| illegal_cmd_o | output | 4 | Code of the illegal command |
| illegal_ba_o | output | BA_W | Bank of the illegal command |

## Verification
A table-driven command stream takes the tracker through every state. In each state it issues at least one legal and one illegal command. This separates the per-state legality rules from the plain decode, and an illegal command placed inside a timed wait shows that the remaining count is frozen rather than advanced. Runs of no-ops are counted to the exact exit cycle of each timed state, which tells the recovery, precharge, refresh and mode-load waits apart. Clock-enable patterns show three different cases: a command that is ignored, a power-state entry, and an illegal command with a falling clock enable. Reset in the middle of a sequence confirms that the first command after reset is judged.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [3:0] {
        C_DESEL = 4'd0,
        C_NOP   = 4'd1,
        C_BST   = 4'd2,
        C_READ  = 4'd3,
        C_WRITE = 4'd4,
        C_ACT   = 4'd5,
        C_PRE   = 4'd6,
        C_REF   = 4'd7,
        C_MRS   = 4'd8
    } cmd_e;

    typedef enum logic [3:0] {
        S_IDLE    = 4'd0,
        S_ACTIVE  = 4'd1,
        S_WREC    = 4'd2,
        S_WREC_AP = 4'd3,
        S_PRECH   = 4'd4,
        S_REFR    = 4'd5,
        S_MRLOAD  = 4'd6,
        S_PDOWN   = 4'd7,
        S_SELF    = 4'd8
    } trk_state_e;

    // state reached when the wait of a timed state runs out
    function automatic trk_state_e expiry_target(trk_state_e s);
        case (s)
            S_WREC:    return S_ACTIVE;
            S_WREC_AP: return S_PRECH;
            default:   return S_IDLE;
        endcase
    endfunction

    function automatic logic is_timed(trk_state_e s);
        return (s == S_WREC) || (s == S_WREC_AP) || (s == S_PRECH) ||
               (s == S_REFR) || (s == S_MRLOAD);
    endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        if (cs_n) begin
            cmd = C_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd = C_NOP;
                3'b110:  cmd = C_BST;
                3'b101:  cmd = C_READ;
                3'b100:  cmd = C_WRITE;
                3'b011:  cmd = C_ACT;
                3'b010:  cmd = C_PRE;
                3'b001:  cmd = C_REF;
                default: cmd = C_MRS;
            endcase
        end
    end
endmodule

// File: rtl/sdcmd_rules.sv
module sdcmd_rules
    import sdcmd_pkg::*;
(
    input  trk_state_e state,
    input  cmd_e       cmd,
    input  logic       a10,
    output logic       legal,
    output logic       go,
    output trk_state_e tgt
);
    // waiting commands: always accepted, never move the state by themselves
    logic quiet3;
    logic quiet2;

    assign quiet3 = (cmd == C_DESEL) || (cmd == C_NOP) || (cmd == C_BST);
    assign quiet2 = (cmd == C_DESEL) || (cmd == C_NOP);

    always_comb begin
        legal = 1'b1;
        go    = 1'b0;
        tgt   = state;
        case (state)
            S_IDLE: begin
                case (cmd)
                    C_ACT:   begin go = 1'b1; tgt = S_ACTIVE; end
                    C_REF:   begin go = 1'b1; tgt = S_REFR;   end
                    C_MRS:   begin go = 1'b1; tgt = S_MRLOAD; end
                    C_READ,
                    C_WRITE: legal = 1'b0;
                    default: legal = 1'b1;
                endcase
            end
            S_ACTIVE, S_WREC: begin
                case (cmd)
                    C_WRITE: begin go = 1'b1; tgt = a10 ? S_WREC_AP : S_WREC; end
                    C_READ:  begin go = 1'b1; tgt = a10 ? S_PRECH : S_ACTIVE; end
                    C_PRE:   begin
                        legal = (state == S_ACTIVE);
                        go    = (state == S_ACTIVE);
                        tgt   = S_PRECH;
                    end
                    default: legal = quiet3;
                endcase
            end
            S_WREC_AP, S_PRECH, S_REFR: legal = quiet3;
            S_MRLOAD:                   legal = quiet2;
            default:                    legal = 1'b1;
        endcase
    end
endmodule

// File: rtl/sdcmd_tracker.sv
module sdcmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int T_WR  = 2,
    parameter int T_RP  = 3,
    parameter int T_RC  = 6,
    parameter int T_MRD = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    output logic [3:0]      state_o,
    output logic            illegal_o,
    output logic [3:0]      illegal_cmd_o,
    output logic [BA_W-1:0] illegal_ba_o
);
    localparam int T_MAX1 = (T_WR > T_RP) ? T_WR : T_RP;
    localparam int T_MAX2 = (T_RC > T_MRD) ? T_RC : T_MRD;
    localparam int T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
    localparam int CNT_W  = (T_MAX > 1) ? $clog2(T_MAX) : 1;

    typedef struct packed {
        trk_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic            cke;
        logic            ill;
        cmd_e            code;
        logic [BA_W-1:0] bank;
    } trk_t;

    function automatic logic [CNT_W-1:0] load_for(trk_state_e s);
        case (s)
            S_WREC, S_WREC_AP: return CNT_W'(T_WR - 1);
            S_PRECH:           return CNT_W'(T_RP - 1);
            S_REFR:            return CNT_W'(T_RC - 1);
            S_MRLOAD:          return CNT_W'(T_MRD - 1);
            default:           return '0;
        endcase
    endfunction

    trk_t       trk_q, trk_d;
    cmd_e       cmd;
    cmd_e       eff_cmd;
    logic       legal;
    logic       go;
    trk_state_e tgt;
    trk_state_e exp_st;

    sdcmd_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    // commands only count when clock enable was high at the previous edge
    assign eff_cmd = trk_q.cke ? cmd : C_NOP;

    sdcmd_rules u_rules (
        .state (trk_q.st),
        .cmd   (eff_cmd),
        .a10   (a10),
        .legal (legal),
        .go    (go),
        .tgt   (tgt)
    );

    assign exp_st = expiry_target(trk_q.st);

    always_comb begin
        trk_d      = trk_q;
        trk_d.cke  = cke;
        trk_d.ill  = 1'b0;
        trk_d.code = C_DESEL;
        trk_d.bank = '0;
        if (trk_q.st == S_PDOWN || trk_q.st == S_SELF) begin
            if (cke) begin
                trk_d.st = S_IDLE;
            end
        end else if (trk_q.st == S_IDLE && trk_q.cke && !cke) begin
            if (cmd == C_REF) begin
                trk_d.st = S_SELF;
            end else if (cmd == C_NOP || cmd == C_DESEL) begin
                trk_d.st = S_PDOWN;
            end else begin
                trk_d.ill  = 1'b1;
                trk_d.code = cmd;
                trk_d.bank = ba;
            end
        end else if (!legal) begin
            trk_d.ill  = 1'b1;
            trk_d.code = cmd;
            trk_d.bank = ba;
        end else if (go) begin
            trk_d.st  = tgt;
            trk_d.cnt = load_for(tgt);
        end else if (is_timed(trk_q.st)) begin
            if (trk_q.cnt == '0) begin
                trk_d.st  = exp_st;
                trk_d.cnt = load_for(exp_st);
            end else begin
                trk_d.cnt = trk_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= '{st: S_IDLE, cnt: '0, cke: 1'b1, ill: 1'b0,
                       code: C_DESEL, bank: '0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign state_o       = trk_q.st;
    assign illegal_o     = trk_q.ill;
    assign illegal_cmd_o = trk_q.code;
    assign illegal_ba_o  = trk_q.bank;

endmodule

// File: rtl/sdcmd_tracker_chk.sv
module sdcmd_tracker_chk (
    input logic       clk,
    input logic       rst,
    input logic       cke,
    input logic [3:0] state_o,
    input logic       illegal_o,
    input logic [3:0] illegal_cmd_o
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    assert_hold_on_illegal_R9: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && illegal_o) |-> (state_o == $past(state_o)));

    assert_code_valid_R9: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (illegal_cmd_o != 4'd0 && illegal_cmd_o <= 4'd8));

    assert_code_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !illegal_o |-> (illegal_cmd_o == 4'd0));

    assert_ignored_cke_R10: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && !$past(cke, 2)) |-> !illegal_o);

    assert_wrecap_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && $past(state_o) == 4'd3 && state_o != 4'd3) |-> (state_o == 4'd4));

    assert_prech_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && $past(state_o) == 4'd4 && state_o != 4'd4) |-> (state_o == 4'd0));

    assert_refresh_exit_R7: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && $past(state_o) == 4'd5 && state_o != 4'd5) |-> (state_o == 4'd0));

    assert_mrload_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && $past(state_o) == 4'd6 && state_o != 4'd6) |-> (state_o == 4'd0));

    assert_power_entry_R11: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && (state_o == 4'd7 || state_o == 4'd8) && $past(state_o) != state_o)
        |-> ($past(state_o) == 4'd0 && !$past(cke)));

    assert_power_exit_R11: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && ($past(state_o) == 4'd7 || $past(state_o) == 4'd8) &&
         state_o != $past(state_o)) |-> (state_o == 4'd0 && $past(cke)));

endmodule

bind sdcmd_tracker sdcmd_tracker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cke           (cke),
    .state_o       (state_o),
    .illegal_o     (illegal_o),
    .illegal_cmd_o (illegal_cmd_o)
);

// File: tb/sdcmd_tracker_bench.sv
module sdcmd_tracker_bench;
    localparam int BA_W = 2;
    localparam int NV   = 51;

    logic            clk = 1'b0;
    logic            rst;
    logic            cke;
    logic            cs_n, ras_n, cas_n, we_n;
    logic [BA_W-1:0] ba;
    logic            a10;
    logic [3:0]      state_o;
    logic            illegal_o;
    logic [3:0]      illegal_cmd_o;
    logic [BA_W-1:0] illegal_ba_o;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    sdcmd_tracker #(.BA_W(BA_W), .T_WR(2), .T_RP(3), .T_RC(6), .T_MRD(2)) u_sdcmd_tracker (
        .clk (clk), .rst (rst), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
        .cas_n (cas_n), .we_n (we_n), .ba (ba), .a10 (a10),
        .state_o (state_o), .illegal_o (illegal_o),
        .illegal_cmd_o (illegal_cmd_o), .illegal_ba_o (illegal_ba_o)
    );

    // {cke, cmd, a10, ba, expected state, expected flag, expected code}
    function automatic logic [16:0] v(input logic k, input logic [3:0] c, input logic a,
                                      input logic [1:0] b, input logic [3:0] s,
                                      input logic f, input logic [3:0] code);
        return {k, c, a, b, s, f, code};
    endfunction

    localparam logic [16:0] VEC [NV] = '{
        v(1,1,0,0, 0,0,0),  // R2 idle no-op
        v(1,3,0,2, 0,1,3),  // R2 read illegal in idle
        v(1,5,0,0, 1,0,0),  // R2 activate
        v(1,5,0,1, 1,1,5),  // R3 activate illegal when open
        v(1,4,0,0, 2,0,0),  // R3 write -> recovery
        v(1,1,0,0, 2,0,0),  // R4 wait
        v(1,1,0,0, 1,0,0),  // R4 expiry after T_WR
        v(1,4,0,0, 2,0,0),  // R3 write again
        v(1,6,0,3, 2,1,6),  // R4 precharge illegal, count frozen
        v(1,4,1,0, 3,0,0),  // R4 new write with a10
        v(1,3,0,0, 3,1,3),  // R5 read illegal
        v(1,1,0,0, 3,0,0),  // R5 wait
        v(1,1,0,0, 4,0,0),  // R5 expiry to precharging
        v(1,1,0,0, 4,0,0),  // R6
        v(1,5,0,0, 4,1,5),  // R6 activate illegal
        v(1,1,0,0, 4,0,0),  // R6
        v(1,1,0,0, 0,0,0),  // R6 expiry to idle
        v(1,7,0,0, 5,0,0),  // R2 refresh
        v(1,2,0,0, 5,0,0),  // R7 burst stop accepted
        v(1,5,0,0, 5,1,5),  // R7 activate illegal
        v(1,1,0,0, 5,0,0),  // R7
        v(1,1,0,0, 5,0,0),  // R7
        v(1,1,0,0, 5,0,0),  // R7
        v(1,1,0,0, 5,0,0),  // R7
        v(1,1,0,0, 0,0,0),  // R7 expiry
        v(1,8,0,0, 6,0,0),  // R2 mode load
        v(1,2,0,0, 6,1,2),  // R8 burst stop illegal
        v(1,1,0,0, 6,0,0),  // R8
        v(1,1,0,0, 0,0,0),  // R8 expiry
        v(1,5,0,0, 1,0,0),  // R2
        v(1,4,0,0, 2,0,0),  // R3
        v(1,3,0,0, 1,0,0),  // R4 read ends recovery
        v(1,3,1,0, 4,0,0),  // R3 read with auto-precharge
        v(1,0,0,0, 4,0,0),  // R6 deselect
        v(1,0,0,0, 4,0,0),  // R6
        v(1,0,0,0, 0,0,0),  // R6 expiry
        v(0,1,0,0, 7,0,0),  // R11 power-down entry
        v(0,3,0,0, 7,0,0),  // R11 pins ignored
        v(1,1,0,0, 0,0,0),  // R11 exit
        v(1,3,0,0, 0,1,3),  // R2 read judged again
        v(0,7,0,0, 8,0,0),  // R11 self refresh entry
        v(1,1,0,0, 0,0,0),  // R11 exit
        v(1,5,0,0, 1,0,0),  // R2
        v(0,8,0,2, 1,1,8),  // R3 mode load illegal
        v(1,8,0,0, 1,0,0),  // R10 ignored after low clock enable
        v(1,6,0,0, 4,0,0),  // R3 precharge
        v(1,1,0,0, 4,0,0),  // R6
        v(1,1,0,0, 4,0,0),  // R6
        v(1,1,0,0, 0,0,0),  // R6
        v(0,5,0,1, 0,1,5),  // R11 activate with falling clock enable
        v(1,1,0,0, 0,0,0)   // R10 ignored
    };

    task automatic drive(input logic k, input logic [3:0] c, input logic a, input logic [1:0] b);
        cke = k; a10 = a; ba = b;
        case (c)
            4'd0:    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
            4'd1:    {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            4'd2:    {cs_n, ras_n, cas_n, we_n} = 4'b0110;
            4'd3:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
            4'd4:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
            4'd5:    {cs_n, ras_n, cas_n, we_n} = 4'b0011;
            4'd6:    {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            4'd7:    {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
        endcase
    endtask

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic step(input logic k, input logic [3:0] c, input logic a, input logic [1:0] b);
        drive(k, c, a, b);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b1, 4'd1, 1'b0, 2'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        check("R12 state", state_o, 0);
        check("R12 flag", illegal_o, 0);
        check("R12 code", illegal_cmd_o, 0);

        for (int i = 0; i < NV; i++) begin
            logic [16:0] e;
            e = VEC[i];
            step(e[16], e[15:12], e[11], e[10:9]);
            check($sformatf("R1-table row %0d state", i), state_o, int'(e[8:5]));
            check($sformatf("R9 row %0d flag", i), illegal_o, int'(e[4]));
            check($sformatf("R1 row %0d code", i), illegal_cmd_o, int'(e[3:0]));
            check($sformatf("R9 row %0d bank", i), illegal_ba_o, e[4] ? int'(e[10:9]) : 0);
        end

        // R12: reset in the middle of a sequence
        step(1'b1, 4'd5, 1'b0, 2'd0);
        check("R2 activate before reset", state_o, 1);
        rst = 1'b1;
        step(1'b0, 4'd4, 1'b0, 2'd0);
        rst = 1'b0;
        check("R12 state after mid reset", state_o, 0);
        check("R12 flag after mid reset", illegal_o, 0);
        // first command after reset is judged even though cke was low during reset
        step(1'b1, 4'd3, 1'b0, 2'd1);
        check("R12 first command judged", illegal_o, 1);
        check("R12 first command code", illegal_cmd_o, 3);
        // R3: all-bank precharge from open row
        step(1'b1, 4'd5, 1'b0, 2'd0);
        step(1'b1, 4'd6, 1'b1, 2'd0);
        check("R3 precharge-all", state_o, 4);
        // R9: flag lasts one cycle when next command is legal
        step(1'b1, 4'd5, 1'b0, 2'd0);
        check("R9 illegal in precharge", illegal_o, 1);
        step(1'b1, 4'd1, 1'b0, 2'd0);
        check("R9 flag drops", illegal_o, 0);
        check("R9 code clears", illegal_cmd_o, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule